// File: doc/BRIEF.md
# Pseudo-Random Helicity Pattern Sequencer

This block chooses the helicity state of every helicity window. Windows are grouped into multiplets: a pair, a quartet or an octet. Each multiplet follows one of two complementary templates. In random mode a 30-bit maximal-length shift register picks the template. In toggle mode successive multiplets alternate it. A timing generator outside the block issues a one-cycle window-advance strobe at every window boundary. All outputs of the block change on that strobe.

The block drives the real-time helicity and its complement. It also drives a reported copy of the helicity delayed by a programmable number of windows, a pair sync, a multiplet sync, and two attenuator-control bits. These two bits carry the polarity of the current multiplet and of the previous multiplet, so downstream feedback can use both the present and the preceding state. A seed input reloads the shift register and restarts the multiplet framing.

Top module: `helicity_seq`

## Requirements
- R1: In random mode the shift register advances exactly once per multiplet, at the multiplet's first window. The new bit is the XOR of register bits 30, 29, 28 and 7 (1-indexed). The register shifts left, and the new bit enters bit 1. This new bit is the multiplet polarity, and 1 selects the first template form.
- R2: A `seed_load` pulse loads `seed` into the register, and a seed of zero is loaded as 1. The register never holds zero. The next window, or a window in the same cycle, starts a new multiplet.
- R3: `pat_sel` encoding: 0 = pair, 1 = quartet, 2 and 3 = octet. The first template forms are pair +-, quartet -++- and octet +--+-++-. Here + is `hel_rt`=1 and the first listed state is the first window. Polarity 0 gives the bitwise complement of the first form.
- R4: In toggle mode the first multiplet after reset has polarity 1. Each later toggle-mode multiplet has the inverse of the previous multiplet's polarity.
- R5: `pat_sel` and `rand_mode` are sampled only at a multiplet's first window. A change in the middle of a multiplet takes effect at the next multiplet.
- R6: After reset `hel_rt`, `hel_rep`, `pair_sync`, `mult_sync`, `ia1` and `ia2` are 0, and `hel_rt_n` is 1. `hel_rt_n` is always the inverse of `hel_rt`.
- R7: Outputs update one clock after a cycle with `win_adv`=1. In every other cycle they hold, whatever `pat_sel`, `rand_mode`, `rep_delay` and `seed_load` do.
- R8: `pair_sync` is 1 in windows at even positions (0, 2, 4, 6) of the multiplet. `mult_sync` is 1 only in position 0.
- R9: `ia1` is the polarity of the current multiplet. `ia2` is the polarity of the multiplet before it, or 0 if there was none.
- R10: `hel_rep` equals the `hel_rt` of n windows earlier, where n = `rep_delay` clamped to 1000, and n = 0 gives `hel_rt` itself. It is 0 while fewer than n windows have passed since reset.
- R11: When `seed_load` and `win_adv` coincide in the middle of a multiplet, that window is the first window of a new multiplet. Its polarity is taken from the freshly loaded seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_adv | input | 1 | One-cycle strobe: a new helicity window begins |
| pat_sel | input | 2 | Multiplet pattern select |
| rand_mode | input | 1 | 1 = shift-register polarity, 0 = toggle polarity |
| seed_load | input | 1 | Load `seed` into the shift register and restart framing |
| seed | input | 30 | Shift-register seed |
| rep_delay | input | 10 | Reporting delay in windows |
| hel_rt | output | 1 | Real-time helicity |
| hel_rt_n | output | 1 | Complement of real-time helicity |
| hel_rep | output | 1 | Delayed (reported) helicity |
| pair_sync | output | 1 | Pair framing marker |
| mult_sync | output | 1 | First-window-of-multiplet marker |
| ia1 | output | 1 | Current multiplet polarity |
| ia2 | output | 1 | Previous multiplet polarity |

## Verification
A seed reload and a window advance can arrive in the same cycle. This cycle mixes the register load, the new-bit computation and the framing restart. The bench provokes it by pulsing `seed_load` together with `win_adv` in the middle of a quartet. It then compares every output of that window and of the following windows against a reference model that restarts the multiplet from the new seed at that window. A load without a window, issued while the window advance is idle, is also covered: all outputs must hold, and the restart must appear at the next window.

// File: rtl/hel_pkg.sv
package hel_pkg;

    typedef enum logic [1:0] {
        PAT_PAIR  = 2'd0,
        PAT_QUAD  = 2'd1,
        PAT_OCT   = 2'd2,
        PAT_OCT_B = 2'd3
    } pat_e;

    localparam int POS_W = 3;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        pat_e             pat;
        logic             fresh;
        logic             pol;
        logic             prev;
        logic             hel;
        logic             psync;
        logic             msync;
    } frame_st_t;

    // Index of the last window of a multiplet.
    function automatic logic [POS_W-1:0] last_pos(input pat_e p);
        case (p)
            PAT_PAIR: last_pos = POS_W'(1);
            PAT_QUAD: last_pos = POS_W'(3);
            default:  last_pos = POS_W'(7);
        endcase
    endfunction

    // State of the first template form at a given window position.
    function automatic logic first_form(input pat_e p, input logic [POS_W-1:0] pos);
        case (p)
            PAT_PAIR: first_form = ~pos[0];
            PAT_QUAD: first_form = ^pos[1:0];
            default:  first_form = ~(^pos);
        endcase
    endfunction

endpackage

// File: rtl/hel_lfsr.sv
module hel_lfsr #(
    parameter int           W          = 30,
    parameter int           TAP_A      = 30,
    parameter int           TAP_B      = 29,
    parameter int           TAP_C      = 28,
    parameter int           TAP_D      = 7,
    parameter logic [W-1:0] RESET_SEED = 30'h2AAAAAAA
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         adv,
    output logic         new_bit
);

    logic [W-1:0] st_q, st_d, eff;

    always_comb begin
        eff = st_q;
        if (load) begin
            eff = (seed == '0) ? W'(1) : seed;
        end
        new_bit = eff[TAP_A-1] ^ eff[TAP_B-1] ^ eff[TAP_C-1] ^ eff[TAP_D-1];
        st_d    = adv ? {eff[W-2:0], new_bit} : eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_SEED;
        else        st_q <= st_d;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0); // R2
    AST_LFSR_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> st_q[0] == $past(new_bit)); // R1

endmodule

// File: rtl/hel_frame.sv
module hel_frame
    import hel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_adv,
    input  logic seed_load,
    input  pat_e pat_sel,
    input  logic rand_mode,
    input  logic rnd_bit,
    output logic lfsr_adv,
    output logic mstart,
    output logic hel_nxt,
    output logic hel,
    output logic psync,
    output logic msync,
    output logic pol,
    output logic prev
);

    localparam frame_st_t RST = '{
        pos: '0, pat: PAT_PAIR, fresh: 1'b1, pol: 1'b0, prev: 1'b0,
        hel: 1'b0, psync: 1'b0, msync: 1'b0
    };

    frame_st_t st_q, st_d;
    logic      fresh_eff;
    logic      at_last;

    always_comb begin
        st_d      = st_q;
        fresh_eff = st_q.fresh | seed_load;
        at_last   = (st_q.pos == last_pos(st_q.pat));
        mstart    = win_adv & (fresh_eff | at_last);
        lfsr_adv  = mstart & rand_mode;

        if (win_adv) begin
            if (mstart) begin
                st_d.pat   = pat_sel;
                st_d.pos   = '0;
                st_d.prev  = st_q.pol;
                st_d.pol   = rand_mode ? rnd_bit : ~st_q.pol;
                st_d.fresh = 1'b0;
            end else begin
                st_d.pos   = st_q.pos + POS_W'(1);
            end
            st_d.hel   = first_form(st_d.pat, st_d.pos) ^ ~st_d.pol;
            st_d.psync = ~st_d.pos[0];
            st_d.msync = (st_d.pos == '0);
        end else if (seed_load) begin
            st_d.fresh = 1'b1;
        end
        hel_nxt = st_d.hel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RST;
        else        st_q <= st_d;
    end

    assign hel   = st_q.hel;
    assign psync = st_q.psync;
    assign msync = st_q.msync;
    assign pol   = st_q.pol;
    assign prev  = st_q.prev;

    AST_RANDOM_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (mstart && rand_mode) |=> st_q.pol == $past(rnd_bit)); // R1
    AST_TOGGLE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (mstart && !rand_mode) |=> st_q.pol != $past(st_q.pol)); // R4
    AST_HISTORY_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        mstart |=> st_q.prev == $past(st_q.pol)); // R9
    AST_PATTERN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv && !mstart) |=> $stable(st_q.pat)); // R5

endmodule

// File: rtl/hel_report.sv
module hel_report #(
    parameter int DEPTH   = 1024,
    parameter int MAX_DLY = 1000,
    parameter int DLY_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_adv,
    input  logic             hel_nxt,
    input  logic [DLY_W-1:0] rep_delay,
    output logic             hel_rep
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [CNT_W-1:0] cnt;
        logic             rep;
    } rep_st_t;

    rep_st_t          st_q, st_d;
    logic             hist_q [DEPTH];
    logic [DLY_W-1:0] n_eff;
    logic [PTR_W-1:0] rd_ptr;

    always_comb begin
        st_d   = st_q;
        n_eff  = (rep_delay > DLY_W'(MAX_DLY)) ? DLY_W'(MAX_DLY) : rep_delay;
        rd_ptr = st_q.wp - PTR_W'(n_eff);
        if (win_adv) begin
            st_d.wp = st_q.wp + PTR_W'(1);
            if (st_q.cnt != CNT_W'(DEPTH)) st_d.cnt = st_q.cnt + CNT_W'(1);
            if (n_eff == '0)                    st_d.rep = hel_nxt;
            else if (st_q.cnt >= CNT_W'(n_eff)) st_d.rep = hist_q[rd_ptr];
            else                                st_d.rep = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (win_adv) hist_q[st_q.wp] <= hel_nxt;
    end

    assign hel_rep = st_q.rep;

    AST_REP_EARLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv && n_eff != '0 && st_q.cnt < CNT_W'(n_eff)) |=> !hel_rep); // R10
    AST_REP_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_adv && n_eff == '0) |=> hel_rep == $past(hel_nxt)); // R10

endmodule

// File: rtl/helicity_seq.sv
module helicity_seq #(
    parameter int            LFSR_W     = 30,
    parameter logic [29:0]   RESET_SEED = 30'h2AAAAAAA,
    parameter int            DEPTH      = 1024,
    parameter int            MAX_DLY    = 1000,
    parameter int            DLY_W      = $clog2(MAX_DLY + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_adv,
    input  logic [1:0]        pat_sel,
    input  logic              rand_mode,
    input  logic              seed_load,
    input  logic [LFSR_W-1:0] seed,
    input  logic [DLY_W-1:0]  rep_delay,
    output logic              hel_rt,
    output logic              hel_rt_n,
    output logic              hel_rep,
    output logic              pair_sync,
    output logic              mult_sync,
    output logic              ia1,
    output logic              ia2
);
    import hel_pkg::*;

    logic lfsr_adv, rnd_bit, mstart, hel_nxt;

    hel_lfsr #(
        .W          (LFSR_W),
        .RESET_SEED (LFSR_W'(RESET_SEED))
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (seed_load),
        .seed    (seed),
        .adv     (lfsr_adv),
        .new_bit (rnd_bit)
    );

    hel_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_adv   (win_adv),
        .seed_load (seed_load),
        .pat_sel   (pat_e'(pat_sel)),
        .rand_mode (rand_mode),
        .rnd_bit   (rnd_bit),
        .lfsr_adv  (lfsr_adv),
        .mstart    (mstart),
        .hel_nxt   (hel_nxt),
        .hel       (hel_rt),
        .psync     (pair_sync),
        .msync     (mult_sync),
        .pol       (ia1),
        .prev      (ia2)
    );

    hel_report #(
        .DEPTH   (DEPTH),
        .MAX_DLY (MAX_DLY),
        .DLY_W   (DLY_W)
    ) u_report (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_adv   (win_adv),
        .hel_nxt   (hel_nxt),
        .rep_delay (rep_delay),
        .hel_rep   (hel_rep)
    );

    assign hel_rt_n = ~hel_rt;

    AST_HOLD_NO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !win_adv |=> ($stable(hel_rt) && $stable(hel_rep) && $stable(ia1) && $stable(mult_sync))); // R7
    AST_MSYNC_IMPLIES_PSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        mult_sync |-> pair_sync); // R8
    AST_RELOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && win_adv) |=> mult_sync); // R11

endmodule

// File: tb/helicity_seq_bench.sv
module helicity_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        win_adv;
    logic [1:0]  pat_sel;
    logic        rand_mode;
    logic        seed_load;
    logic [29:0] seed;
    logic [9:0]  rep_delay;
    logic        hel_rt, hel_rt_n, hel_rep, pair_sync, mult_sync, ia1, ia2;

    always #2 clk = ~clk;

    helicity_seq u_helicity_seq (
        .clk(clk), .rst_n(rst_n), .win_adv(win_adv), .pat_sel(pat_sel),
        .rand_mode(rand_mode), .seed_load(seed_load), .seed(seed),
        .rep_delay(rep_delay), .hel_rt(hel_rt), .hel_rt_n(hel_rt_n),
        .hel_rep(hel_rep), .pair_sync(pair_sync), .mult_sync(mult_sync),
        .ia1(ia1), .ia2(ia2)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // First template forms, first window in the MSB.
    localparam logic [1:0] TP_PAIR = 2'b10;
    localparam logic [3:0] TP_QUAD = 4'b0110;
    localparam logic [7:0] TP_OCT  = 8'b10010110;

    typedef struct packed {
        logic [1:0] pat;
        logic [7:0] hel;
        logic [7:0] ms;
    } vec_t;

    localparam vec_t TBL [3] = '{
        '{pat: 2'd0, hel: 8'b10011001, ms: 8'b10101010},
        '{pat: 2'd1, hel: 8'b01101001, ms: 8'b10001000},
        '{pat: 2'd2, hel: 8'b10010110, ms: 8'b10000000}
    };

    // Reference model state
    logic [29:0] m_lfsr;
    int          m_pos, m_len, m_k;
    logic [1:0]  m_pat;
    logic        m_fresh, m_pol, m_prev;
    logic        m_hist [0:2047];

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    function automatic int plen(input logic [1:0] p);
        return (p == 2'd0) ? 2 : (p == 2'd1) ? 4 : 8;
    endfunction

    task automatic m_reset();
        m_lfsr = 30'h2AAAAAAA; m_pos = 0; m_len = 2; m_k = 0; m_pat = 2'd0;
        m_fresh = 1'b1; m_pol = 1'b0; m_prev = 1'b0;
    endtask

    task automatic m_load(input logic [29:0] sd);
        m_lfsr  = (sd == 30'd0) ? 30'd1 : sd;
        m_fresh = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; win_adv = 1'b0; seed_load = 1'b0; pat_sel = 2'd0;
        rand_mode = 1'b0; seed = '0; rep_delay = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
    endtask

    // One window: drive, let one edge pass, update the model, compare.
    task automatic win_step(input logic [1:0] pat, input logic rnd,
                            input logic ld, input logic [29:0] sd);
        logic nb, f, h, er;
        int   d;
        pat_sel = pat; rand_mode = rnd; seed_load = ld; seed = sd; win_adv = 1'b1;
        @(negedge clk);
        win_adv = 1'b0; seed_load = 1'b0;
        if (ld) m_load(sd);
        if (m_fresh || m_pos == m_len - 1) begin
            m_pat = pat; m_len = plen(pat); m_pos = 0; m_prev = m_pol; m_fresh = 1'b0;
            if (rnd) begin
                nb = m_lfsr[29] ^ m_lfsr[28] ^ m_lfsr[27] ^ m_lfsr[6];
                m_lfsr = {m_lfsr[28:0], nb};
                m_pol = nb;
            end else begin
                m_pol = ~m_pol;
            end
        end else begin
            m_pos++;
        end
        case (m_pat)
            2'd0:    f = TP_PAIR[1 - m_pos];
            2'd1:    f = TP_QUAD[3 - m_pos];
            default: f = TP_OCT[7 - m_pos];
        endcase
        h = m_pol ? f : ~f;
        m_hist[m_k] = h;
        d = (int'(rep_delay) > 1000) ? 1000 : int'(rep_delay);
        er = (d == 0) ? h : ((m_k >= d) ? m_hist[m_k - d] : 1'b0);
        m_k++;
        chk("R1 R3 R5 R11 hel_rt", hel_rt, h);
        chk("R6 hel_rt_n", hel_rt_n, ~h);
        chk("R10 hel_rep", hel_rep, er);
        chk("R8 pair_sync", pair_sync, (m_pos % 2) == 0);
        chk("R8 mult_sync", mult_sync, m_pos == 0);
        chk("R9 ia1", ia1, m_pol);
        chk("R9 ia2", ia2, m_prev);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R7 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [6:0] snap;

        // Reset state (R6)
        do_reset();
        chk("R6 reset hel_rt", hel_rt, 1'b0);
        chk("R6 reset hel_rt_n", hel_rt_n, 1'b1);
        chk("R6 reset hel_rep", hel_rep, 1'b0);
        chk("R6 reset pair_sync", pair_sync, 1'b0);
        chk("R6 reset mult_sync", mult_sync, 1'b0);
        chk("R6 reset ia1", ia1, 1'b0);
        chk("R6 reset ia2", ia2, 1'b0);

        // Table walk: toggle-mode templates (R3, R4, R8)
        foreach (TBL[v]) begin
            do_reset();
            pat_sel = TBL[v].pat;
            for (int i = 0; i < 8; i++) begin
                win_adv = 1'b1;
                @(negedge clk);
                win_adv = 1'b0;
                chk("R3 R4 table hel_rt", hel_rt, TBL[v].hel[7 - i]);
                chk("R8 table mult_sync", mult_sync, TBL[v].ms[7 - i]);
                chk("R8 table pair_sync", pair_sync, (i % 2) == 0);
            end
        end

        // Random and toggle mix, pattern changed every window (R1, R5, R9, R10)
        do_reset();
        rep_delay = 10'd3;
        seed = 30'h01234567; seed_load = 1'b1;
        @(negedge clk);
        seed_load = 1'b0;
        m_load(30'h01234567);
        for (int i = 0; i < 48; i++) begin
            win_step(2'(i % 3), ((i / 8) % 2) == 0, 1'b0, '0);
        end

        // Hold without window; a bare seed load restarts framing later (R7, R2)
        win_step(2'd1, 1'b1, 1'b0, '0);
        snap = {hel_rt, hel_rt_n, hel_rep, pair_sync, mult_sync, ia1, ia2};
        for (int i = 0; i < 6; i++) begin
            pat_sel = 2'(i); rand_mode = i[0]; rep_delay = 10'(i);
            seed_load = (i == 2); seed = 30'h00ABCDEF;
            @(negedge clk);
            seed_load = 1'b0;
            chk("R7 hold outputs", {hel_rt, hel_rt_n, hel_rep, pair_sync, mult_sync, ia1, ia2} == snap, 1'b1);
        end
        m_load(30'h00ABCDEF);
        rep_delay = 10'd3;
        for (int i = 0; i < 6; i++) win_step(2'd1, 1'b1, 1'b0, '0);

        // Seed load coinciding with a window mid-quartet (R11)
        win_step(2'd1, 1'b1, 1'b1, 30'h3ABCDEF0);
        for (int i = 0; i < 12; i++) win_step(2'd1, 1'b1, 1'b0, '0);

        // Zero seed becomes 1 (R2)
        win_step(2'd0, 1'b1, 1'b1, 30'd0);
        for (int i = 0; i < 30; i++) win_step(2'd0, 1'b1, 1'b0, '0);

        // Delay above the limit clamps to 1000 (R10)
        do_reset();
        rep_delay = 10'd1023;
        for (int i = 0; i < 1006; i++) win_step(2'd2, 1'b1, 1'b0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule